// File: doc/BRIEF.md
# Transition-Based Heartbeat Supervisor

This block watches a heartbeat square wave, of roughly even duty cycle, that a controlled system produces while it is alive. It raises a fault output, meant to drive something such as a relay enable, as soon as the heartbeat stops changing. Liveness is judged from transitions and never from levels. A heartbeat frozen high and one frozen low are therefore the same failure. The fault is held for as long as the heartbeat is missing. It drops again by itself once the heartbeat is toggling properly, with no reset or acknowledge needed.

The heartbeat first passes through a multi-flop synchronizer. An edge pulse is formed by comparing the synchronized level with its value one clock earlier. A compile-time option counts either every transition or only low-to-high ones; the second option halves the retrigger rate. Each edge pulse restarts a saturating one-shot counter, and the counter expires when it reaches the programmable cycle limit. A small state machine owns the fault. It leaves the fault state only after several edges, each arriving before the counter expires, so that a single glitch cannot clear a fault. The fault is asserted from reset until that condition is met.

Top module: `hbwd_top`

## Requirements
- R1: During and after reset, `fault_o` is 1 and `edge_o` is 0 until heartbeat edges satisfy R6.
- R2: With `EDGE_MODE` = 0, every change of `beat_i` driven between clock edges makes `edge_o` 1 for exactly one cycle: the cycle after the second rising clock edge that follows the change.
- R3: With `EDGE_MODE` = 1, only a 0-to-1 change of `beat_i` produces an `edge_o` pulse (same timing as R2). A 1-to-0 change produces none and does not restart the timeout.
- R4: While healthy, let k be the first rising clock edge after the last counted change of `beat_i`, and T the value of `timeout_i`. Then `fault_o` is still 0 after edge k+T+2 and becomes 1 after edge k+T+3.
- R5: A heartbeat that stops high and one that stops low both raise `fault_o` with the timing of R4.
- R6: In the fault state, `fault_o` clears in the cycle after the edge pulse that completes `RESUME_EDGES` (default 2) consecutive edge pulses. Each of these pulses must come before the counter expires from the previous one. When two changes of `beat_i` are spaced at most T cycles apart, this is satisfied.
- R7: A single isolated edge does not clear `fault_o`. Neither do two edges spaced more than T+1 cycles apart; in that case the later edge starts a new count.
- R8: The timeout counter saturates at its maximum value and never wraps. `timeout_i` = 65535 (all ones at the default width) gives the R4 timing with T = 65535.
- R9: If an edge pulse and counter expiry fall in the same cycle while healthy, expiry wins and `fault_o` rises. That edge counts as the first resume edge, so one more timely edge clears the fault. This is the case where the changes are T+1 cycles apart.
- R10: Two changes spaced exactly T cycles apart keep `fault_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| beat_i | input | 1 | Asynchronous heartbeat from the supervised system |
| timeout_i | input | TMO_W (16) | Allowed gap between counted edges, in clock cycles (at least 1) |
| fault_o | output | 1 | 1 while the heartbeat is considered lost |
| edge_o | output | 1 | One-cycle pulse for every counted heartbeat transition |

## Verification
Two functions can land in the same cycle: an edge pulse restarting the counter, and the counter reaching the limit. The bench provokes this by spacing two heartbeat changes by exactly T+1 cycles, and compares that against a spacing of T cycles. At T+1 the fault must rise. One further edge must then clear it, which shows that the colliding edge was kept as the first resume edge. At T the fault must stay low at the same sampling point.

// File: rtl/hbwd_pkg.sv
package hbwd_pkg;

  typedef enum logic {
    ST_FAULT   = 1'b0,
    ST_HEALTHY = 1'b1
  } hb_state_e;

  localparam int unsigned EDGE_ANY  = 0;
  localparam int unsigned EDGE_RISE = 1;

endpackage

// File: rtl/hbwd_edge.sv
module hbwd_edge #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned EDGE_MODE   = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic beat_i,
  output logic edge_o
);
  import hbwd_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   cur_lvl;

  assign cur_lvl = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], beat_i};
    prev_d = cur_lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  generate
    if (EDGE_MODE == EDGE_RISE) begin : g_rise
      assign edge_o = cur_lvl & ~prev_q;
    end else begin : g_any
      assign edge_o = cur_lvl ^ prev_q;
    end
  endgenerate

endmodule

// File: rtl/hbwd_timer.sv
module hbwd_timer #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             expired_o
);

  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en    = edge_i | (cnt_q != CNT_MAX);
  assign expired_o = (cnt_q >= timeout_i);

  always_comb begin
    if (edge_i) cnt_d = '0;
    else        cnt_d = cnt_q + TMO_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> (cnt_q == '0)); // R4

  AST_CNT_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !edge_i) |=> (cnt_q == CNT_MAX)); // R8

endmodule

// File: rtl/hbwd_fsm.sv
module hbwd_fsm #(
  parameter int unsigned RESUME_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic expired_i,
  output logic fault_o
);
  import hbwd_pkg::*;

  localparam int unsigned GOT_W = $clog2(RESUME_EDGES + 1);

  hb_state_e        state_q, state_d;
  logic [GOT_W-1:0] got_q, got_d;

  always_comb begin
    state_d = state_q;
    got_d   = got_q;
    case (state_q)
      ST_HEALTHY: begin
        if (expired_i) begin
          state_d = ST_FAULT;
          got_d   = edge_i ? GOT_W'(1) : '0;
        end
      end
      default: begin
        if (edge_i) begin
          if (got_q != '0 && !expired_i) got_d = got_q + GOT_W'(1);
          else                           got_d = GOT_W'(1);
          if (got_d == GOT_W'(RESUME_EDGES)) begin
            state_d = ST_HEALTHY;
            got_d   = '0;
          end
        end else if (expired_i) begin
          got_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FAULT;
      got_q   <= '0;
    end else begin
      state_q <= state_d;
      got_q   <= got_d;
    end
  end

  assign fault_o = (state_q == ST_FAULT);

  AST_TRIP_ON_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HEALTHY && expired_i) |=> fault_o); // R9

  AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !edge_i) |=> fault_o); // R7

  AST_CLEAR_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> $past(edge_i)); // R6

endmodule

// File: rtl/hbwd_top.sv
module hbwd_top #(
  parameter int unsigned TMO_W        = 16,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned EDGE_MODE    = 0,
  parameter int unsigned RESUME_EDGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             fault_o,
  output logic             edge_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  logic       edge_w;
  logic       expired_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  hbwd_edge #(
    .SYNC_STAGES(SYNC_STAGES),
    .EDGE_MODE  (EDGE_MODE)
  ) edge_i (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .beat_i(beat_i),
    .edge_o(edge_w)
  );

  hbwd_timer #(
    .TMO_W(TMO_W)
  ) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .edge_i   (edge_w),
    .timeout_i(timeout_i),
    .expired_o(expired_w)
  );

  hbwd_fsm #(
    .RESUME_EDGES(RESUME_EDGES)
  ) fsm_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .edge_i   (edge_w),
    .expired_i(expired_w),
    .fault_o  (fault_o)
  );

  assign edge_o = edge_w;

endmodule

// File: tb/hbwd_top_tb_top.sv
module hbwd_top_tb_top;

  localparam int unsigned T_NOM = 20;

  logic        clk;
  logic        rst_n;
  logic        beat;
  logic [15:0] tmo;
  logic        fault_a, edge_a, fault_r, edge_r;

  int n_chk = 0;
  int n_bad = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  hbwd_top #(.EDGE_MODE(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .beat_i(beat), .timeout_i(tmo),
    .fault_o(fault_a), .edge_o(edge_a));

  hbwd_top #(.EDGE_MODE(1)) dut_r_i (
    .clk_i(clk), .rst_ni(rst_n), .beat_i(beat), .timeout_i(tmo),
    .fault_o(fault_r), .edge_o(edge_r));

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic flip();
    @(negedge clk);
    beat = ~beat;
  endtask

  task automatic run_beats(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      flip();
      repeat (half - 1) @(negedge clk);
    end
  endtask

  // After a flip at the preceding negedge: low after k+T+2, high after k+T+3
  task automatic expect_trip(input int t, input logic both, input string tag);
    repeat (t + 3) @(posedge clk);
    @(negedge clk);
    check(fault_a, 1'b0, {tag, " any-edge unit before expiry"});
    if (both) check(fault_r, 1'b0, {tag, " rise-only unit before expiry"});
    @(posedge clk);
    @(negedge clk);
    check(fault_a, 1'b1, {tag, " any-edge unit at expiry"});
    if (both) check(fault_r, 1'b1, {tag, " rise-only unit at expiry"});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; beat = 1'b0; tmo = 16'(T_NOM);
    repeat (4) @(negedge clk);
    check(fault_a, 1'b1, "R1 fault in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(fault_a, 1'b1, "R1 fault after reset");
    check(edge_a, 1'b0, "R1 edge after reset");
    check(fault_r, 1'b1, "R1 rise-only fault after reset");
  endtask

  task automatic t_edge_pulse();
    flip();
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(edge_a, 1'b1, "R2 pulse on rise");
    check(edge_r, 1'b1, "R3 rise-only pulse on rise");
    @(negedge clk);
    check(edge_a, 1'b0, "R2 pulse one cycle");
    check(fault_a, 1'b1, "R7 one edge keeps fault");
    repeat (4) @(negedge clk);
    flip();
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(edge_a, 1'b1, "R2 pulse on fall");
    check(edge_r, 1'b0, "R3 no pulse on fall");
    @(negedge clk);
    check(fault_a, 1'b0, "R6 cleared after second edge");
    check(fault_r, 1'b1, "R3 rise-only still faulted");
  endtask

  task automatic t_stuck_low();
    run_beats(6, 8);
    check(fault_a, 1'b0, "R6 healthy on heartbeat");
    check(fault_r, 1'b0, "R3 rise-only healthy");
    flip();
    if (beat !== 1'b0) begin
      repeat (7) @(negedge clk);
      flip();
    end
    expect_trip(T_NOM, 1'b0, "R5 stuck low R4");
    check(fault_r, 1'b1, "R3 rise-only tripped earlier");
  endtask

  task automatic t_stuck_high();
    run_beats(6, 8);
    check(fault_a, 1'b0, "R6 healthy again");
    if (beat !== 1'b0) begin
      flip();
      repeat (7) @(negedge clk);
    end
    flip();
    expect_trip(T_NOM, 1'b1, "R5 stuck high R4");
  endtask

  task automatic t_glitch();
    flip();
    repeat (3 * T_NOM) @(negedge clk);
    check(fault_a, 1'b1, "R7 single glitch ignored");
    flip();
    repeat (T_NOM + 8) @(negedge clk);
    flip();
    repeat (4) @(negedge clk);
    check(fault_a, 1'b1, "R7 wide spacing ignored");
    flip();
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check(fault_a, 1'b0, "R6 close pair clears");
  endtask

  task automatic t_collide();
    run_beats(4, 8);
    flip();
    repeat (T_NOM) @(posedge clk);
    @(negedge clk);
    beat = ~beat;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check(fault_a, 1'b0, "R10 spacing T stays healthy");
    run_beats(3, 8);
    flip();
    repeat (T_NOM + 1) @(posedge clk);
    @(negedge clk);
    beat = ~beat;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check(fault_a, 1'b1, "R9 expiry wins over edge");
    repeat (3) @(negedge clk);
    flip();
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check(fault_a, 1'b0, "R9 colliding edge counted");
  endtask

  task automatic t_max_timeout();
    run_beats(4, 8);
    tmo = 16'hFFFF;
    flip();
    expect_trip(65535, 1'b0, "R8 max timeout");
    tmo = 16'(T_NOM);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_edge_pulse();
    t_stuck_low();
    t_stuck_high();
    t_glitch();
    t_collide();
    t_max_timeout();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule